// File: doc/BRIEF.md
# Accumulator ALU with Flag Byte Generation

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each cycle that `in_vld` is high it takes the accumulator byte, a second operand byte, the current flag byte and a 4-bit operation code. It then computes one of fourteen operations: four add/subtract forms, compare, three bitwise logic operations, increment, decrement and four rotates. One clock later it presents a registered result byte, a write enable for the accumulator and the new flag byte.

The flag byte holds sign, zero, nibble carry, even parity and carry. The carry bit doubles as a borrow indicator for subtraction and compare. The surrounding datapath feeds the returned flag byte back into `flg_i` on later operations. This is how the partial-update rules work: increment and decrement keep the old carry, and rotates keep everything except carry.

Top module: `alu8_core`

## Requirements
- R1: While `rst_n` is low and after its release, until the first accepted operation, `out_vld` and `wr_o` are 0, `res_o` is 0 and `flg_o` is 8'h02.
- R2: An operation accepted on a rising edge with `in_vld` high appears on the outputs after that edge, with `out_vld` high for exactly one cycle. When `in_vld` was low at the edge, `out_vld` is low.
- R3: ADD (op 0) gives acc+opd and ADC (op 1) gives acc+opd+CY. Carry (bit 0) is the carry out of bit 7. The nibble carry (bit 4) is the carry from bit 3 into bit 4 of that sum.
- R4: SUB (op 2) gives acc-opd and SBB (op 3) gives acc-opd-CY. Carry is set when the subtraction borrows. The nibble carry is the carry out of bit 3 of acc + ~opd + (1 - borrow-in).
- R5: CMP (op 4) sets every flag exactly as SUB would and drives the difference on `res_o`, but `wr_o` stays 0. All other defined ops drive `wr_o` high.
- R6: For arithmetic and logic results, the flag layout from bit 7 down is: sign, zero, 0, nibble carry, 0, parity, 1, carry. Sign is result bit 7. Zero is set when the result is 8'h00. Parity is set when the result has an even count of ones.
- R7: AND (op 5), OR (op 6) and XOR (op 7) clear carry. AND sets the nibble carry. OR and XOR clear it.
- R8: INC (op 8) gives acc+1 and DEC (op 9) gives acc-1. Both update sign, zero, parity and nibble carry, and keep carry from `flg_i` bit 0. The nibble carry is set for INC when the low nibble was 4'hF, and for DEC when the low nibble was not 0.
- R9: The rotate ops are RLC (op 10, left), RRC (op 11, right), RAL (op 12, left through carry) and RAR (op 13, right through carry). In a plain rotate the outgoing bit fills the vacated bit and also becomes carry. In a through-carry rotate the old carry fills the vacated bit and the outgoing bit becomes carry. Flag bits 7, 6, 4 and 2 are copied from `flg_i`.
- R10: Op codes 14 and 15 drive `res_o` equal to the accumulator and `wr_o` low. They return `flg_i` with bits 5 and 3 forced to 0 and bit 1 forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opd_i | input | 8 | Second operand |
| flg_i | input | 8 | Current flag byte |
| out_vld | output | 1 | Result valid |
| res_o | output | 8 | Result byte |
| wr_o | output | 1 | Accumulator write enable |
| flg_o | output | 8 | Updated flag byte |

## Verification
The hardest flags to reach are the ones that depend on the incoming flag byte as well as the operands. Examples are subtract-with-borrow where the borrow-in alone causes the borrow out, and increment or decrement where a stale carry must come through unchanged. Directed vectors set up these cases, including a 16-bit style two-byte subtraction with a borrow chain. Random operands are also paired with random incoming flag bytes, so that carry-in, carry preservation and the copied flag bits all show up under back-to-back and gapped issue.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_CMP = 4'd4,
        OP_AND = 4'd5,
        OP_OR  = 4'd6,
        OP_XOR = 4'd7,
        OP_INC = 4'd8,
        OP_DEC = 4'd9,
        OP_RLC = 4'd10,
        OP_RRC = 4'd11,
        OP_RAL = 4'd12,
        OP_RAR = 4'd13
    } alu_op_e;

    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_AC = 4;
    localparam int FB_P  = 2;
    localparam int FB_CY = 0;

    localparam logic [7:0] FLG_KEEP_MASK = 8'hD5;
    localparam logic [7:0] FLG_ONE_MASK  = 8'h02;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          cy_o,
    output logic          nib_o
);
    localparam int NIB = DW / 2;

    logic [DW-1:0] b_eff;
    logic          c_eff;
    logic [DW:0]   full;
    logic [NIB:0]  low;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        c_eff = sub_i ? ~cin_i : cin_i;
        full  = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
        low   = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
        sum_o = full[DW-1:0];
        cy_o  = sub_i ? ~full[DW] : full[DW];
        nib_o = low[NIB];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          cy_i,
    input  logic [3:0]    op_i,
    output logic [DW-1:0] res_o,
    output logic          cy_o
);
    import alu8_pkg::*;

    always_comb begin
        res_o = a_i;
        cy_o  = 1'b0;
        case (alu_op_e'(op_i))
            OP_AND: res_o = a_i & b_i;
            OP_OR:  res_o = a_i | b_i;
            OP_XOR: res_o = a_i ^ b_i;
            OP_RLC: begin
                res_o = {a_i[DW-2:0], a_i[DW-1]};
                cy_o  = a_i[DW-1];
            end
            OP_RRC: begin
                res_o = {a_i[0], a_i[DW-1:1]};
                cy_o  = a_i[0];
            end
            OP_RAL: begin
                res_o = {a_i[DW-2:0], cy_i};
                cy_o  = a_i[DW-1];
            end
            OP_RAR: begin
                res_o = {cy_i, a_i[DW-1:1]};
                cy_o  = a_i[0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_status.sv
module alu8_status #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] res_i,
    output logic          sgn_o,
    output logic          zro_o,
    output logic          par_o
);
    always_comb begin
        sgn_o = res_i[DW-1];
        zro_o = (res_i == '0);
        par_o = ~(^res_i);
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] opd_i,
    input  logic [7:0]    flg_i,
    output logic          out_vld,
    output logic [DW-1:0] res_o,
    output logic          wr_o,
    output logic [7:0]    flg_o
);
    import alu8_pkg::*;

    typedef struct packed {
        logic          vld;
        logic          wr;
        logic [DW-1:0] res;
        logic [7:0]    flg;
    } stage_t;

    stage_t st_d, st_q;

    logic [DW-1:0] as_b;
    logic          as_cin, as_sub;
    logic [DW-1:0] as_sum;
    logic          as_cy, as_nib;
    logic [DW-1:0] lg_res;
    logic          lg_cy;
    logic [DW-1:0] mux_res;
    logic          st_s, st_z, st_p;
    logic          old_cy;

    assign old_cy = flg_i[FB_CY];

    always_comb begin
        as_b   = opd_i;
        as_cin = 1'b0;
        as_sub = 1'b0;
        case (alu_op_e'(op_i))
            OP_ADC: as_cin = old_cy;
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_SBB: begin
                as_sub = 1'b1;
                as_cin = old_cy;
            end
            OP_INC: as_b = {{(DW-1){1'b0}}, 1'b1};
            OP_DEC: begin
                as_b   = {{(DW-1){1'b0}}, 1'b1};
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_addsub #(.DW(DW)) u_addsub (
        .a_i   (acc_i),
        .b_i   (as_b),
        .cin_i (as_cin),
        .sub_i (as_sub),
        .sum_o (as_sum),
        .cy_o  (as_cy),
        .nib_o (as_nib)
    );

    alu8_logic #(.DW(DW)) u_logic (
        .a_i   (acc_i),
        .b_i   (opd_i),
        .cy_i  (old_cy),
        .op_i  (op_i),
        .res_o (lg_res),
        .cy_o  (lg_cy)
    );

    always_comb begin
        mux_res = (op_i <= 4'd4 || op_i == 4'd8 || op_i == 4'd9) ? as_sum : lg_res;
    end

    alu8_status #(.DW(DW)) u_status (
        .res_i (mux_res),
        .sgn_o (st_s),
        .zro_o (st_z),
        .par_o (st_p)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.res = mux_res;
            st_d.wr  = 1'b1;
            st_d.flg = (flg_i & FLG_KEEP_MASK) | FLG_ONE_MASK;
            case (alu_op_e'(op_i))
                OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
                    st_d.flg[FB_S]  = st_s;
                    st_d.flg[FB_Z]  = st_z;
                    st_d.flg[FB_P]  = st_p;
                    st_d.flg[FB_AC] = as_nib;
                    st_d.flg[FB_CY] = as_cy;
                    st_d.wr         = (alu_op_e'(op_i) != OP_CMP);
                end
                OP_INC, OP_DEC: begin
                    st_d.flg[FB_S]  = st_s;
                    st_d.flg[FB_Z]  = st_z;
                    st_d.flg[FB_P]  = st_p;
                    st_d.flg[FB_AC] = as_nib;
                end
                OP_AND, OP_OR, OP_XOR: begin
                    st_d.flg[FB_S]  = st_s;
                    st_d.flg[FB_Z]  = st_z;
                    st_d.flg[FB_P]  = st_p;
                    st_d.flg[FB_AC] = (alu_op_e'(op_i) == OP_AND);
                    st_d.flg[FB_CY] = 1'b0;
                end
                OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                    st_d.flg[FB_CY] = lg_cy;
                end
                default: begin
                    st_d.res = acc_i;
                    st_d.wr  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vld <= 1'b0;
            st_q.wr  <= 1'b0;
            st_q.res <= '0;
            st_q.flg <= FLG_ONE_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld = st_q.vld;
    assign res_o   = st_q.res;
    assign wr_o    = st_q.wr & st_q.vld;
    assign flg_o   = st_q.flg;

    p_issue_to_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    p_idle_no_vld_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld && !wr_o);
    p_cmp_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_i == 4'd4) |=> !wr_o);
    p_logic_clears_cy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (op_i == 4'd5 || op_i == 4'd6 || op_i == 4'd7)) |=> !flg_o[FB_CY]);
    p_incdec_keep_cy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && (op_i == 4'd8 || op_i == 4'd9)) |=> flg_o[FB_CY] == $past(flg_i[FB_CY]));
    p_ral_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_i == 4'd12) |=> res_o[0] == $past(flg_i[FB_CY]));
endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_vld = 1'b0;
    logic [3:0] op_i = '0;
    logic [7:0] acc_i = '0, opd_i = '0, flg_i = 8'h02;
    logic       out_vld, wr_o;
    logic [7:0] res_o, flg_o;

    int total = 0;
    int bad = 0;
    int issued = 0;
    int seen = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] res;
        logic       wr;
        logic [7:0] flg;
        logic [3:0] op;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_i(op_i),
        .acc_i(acc_i), .opd_i(opd_i), .flg_i(flg_i),
        .out_vld(out_vld), .res_o(res_o), .wr_o(wr_o), .flg_o(flg_o)
    );

    function automatic string tag_of(logic [3:0] op);
        case (op)
            4'd0, 4'd1:               return "R3";
            4'd2, 4'd3:               return "R4";
            4'd4:                     return "R5";
            4'd5, 4'd6, 4'd7:         return "R7";
            4'd8, 4'd9:               return "R8";
            4'd10, 4'd11, 4'd12, 4'd13: return "R9";
            default:                  return "R10";
        endcase
    endfunction

    function automatic exp_t model(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic [7:0] f);
        exp_t e;
        int   s;
        int   brw;
        logic c, ac, arith;
        logic [7:0] r;
        c = f[0]; ac = f[4]; r = a; arith = 1'b1;
        e.wr = 1'b1;
        brw = 0;
        case (op)
            4'd0, 4'd1: begin
                s  = int'(a) + int'(b) + ((op == 4'd1) ? int'(f[0]) : 0);
                r  = s[7:0]; c = (s > 255);
                ac = ((int'(a & 8'h0F) + int'(b & 8'h0F) + ((op == 4'd1) ? int'(f[0]) : 0)) > 15);
            end
            4'd2, 4'd3, 4'd4: begin
                brw = (op == 4'd3) ? int'(f[0]) : 0;
                s   = int'(a) - int'(b) - brw;
                r   = s[7:0]; c = (s < 0);
                ac  = ((int'(a & 8'h0F) + int'((~b) & 8'h0F) + (1 - brw)) > 15);
                if (op == 4'd4) e.wr = 1'b0;
            end
            4'd5: begin r = a & b; c = 1'b0; ac = 1'b1; end
            4'd6: begin r = a | b; c = 1'b0; ac = 1'b0; end
            4'd7: begin r = a ^ b; c = 1'b0; ac = 1'b0; end
            4'd8: begin r = a + 8'd1; ac = (a[3:0] == 4'hF); end
            4'd9: begin r = a - 8'd1; ac = (a[3:0] != 4'h0); end
            4'd10: begin r = {a[6:0], a[7]}; c = a[7]; arith = 1'b0; end
            4'd11: begin r = {a[0], a[7:1]}; c = a[0]; arith = 1'b0; end
            4'd12: begin r = {a[6:0], f[0]}; c = a[7]; arith = 1'b0; end
            4'd13: begin r = {f[0], a[7:1]}; c = a[0]; arith = 1'b0; end
            default: begin r = a; e.wr = 1'b0; arith = 1'b0; end
        endcase
        e.res = r;
        e.op  = op;
        if (arith)
            e.flg = {r[7], (r == 8'h00), 1'b0, ac, 1'b0, ~(^r), 1'b1, c};
        else
            e.flg = {f[7], f[6], 1'b0, f[4], 1'b0, f[2], 1'b1, c};
        return e;
    endfunction

    task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic issue(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic [7:0] f);
        @(negedge clk);
        in_vld = 1'b1; op_i = op; acc_i = a; opd_i = b; flg_i = f;
        q.push_back(model(op, a, b, f));
        issued++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_vld = 1'b0;
        end
    endtask

    // monitor: scoreboard pop and compare
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            seen++;
            if (q.size() == 0) begin
                check("R2", "unexpected out_vld", 8'd1, 8'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(tag_of(e.op), "res", res_o, e.res);
                check(tag_of(e.op), "wr", {7'd0, wr_o}, {7'd0, e.wr});
                check({tag_of(e.op), "/R6"}, "flags", flg_o, e.flg);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "out_vld in reset", {7'd0, out_vld}, 8'd0);
        check("R1", "flags in reset", flg_o, 8'h02);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "out_vld after reset", {7'd0, out_vld}, 8'd0);
        check("R1", "wr after reset", {7'd0, wr_o}, 8'd0);
        check("R1", "res after reset", res_o, 8'h00);

        // directed corner cases
        issue(4'd0, 8'h3A, 8'hC6, 8'h02);   // R3 zero with carry and nibble carry
        issue(4'd1, 8'hFF, 8'h00, 8'h03);   // R3 carry-in alone overflows
        issue(4'd2, 8'h10, 8'h01, 8'h02);   // R4 nibble borrow
        issue(4'd3, 8'h00, 8'h00, 8'h03);   // R4 borrow-in alone borrows
        issue(4'd3, 8'h34, 8'h12, 8'h03);   // R4 chained low byte borrowed
        issue(4'd4, 8'h05, 8'h05, 8'h02);   // R5 equal compare
        issue(4'd4, 8'h04, 8'h05, 8'h02);   // R5 less-than compare
        issue(4'd5, 8'hF0, 8'h0F, 8'h03);   // R7 AND to zero
        issue(4'd6, 8'h80, 8'h01, 8'h13);   // R7 OR clears AC/CY
        issue(4'd7, 8'hAA, 8'hAA, 8'h13);   // R7 XOR zero
        issue(4'd8, 8'hFF, 8'h00, 8'h03);   // R8 wrap, CY kept set
        issue(4'd9, 8'h00, 8'h00, 8'h02);   // R8 wrap, CY kept clear
        issue(4'd9, 8'h10, 8'h00, 8'h03);   // R8 low nibble zero
        issue(4'd10, 8'h81, 8'h00, 8'hD6);  // R9 plain left
        issue(4'd11, 8'h01, 8'h00, 8'h02);  // R9 plain right
        issue(4'd12, 8'h80, 8'h00, 8'h03);  // R9 through carry left
        issue(4'd13, 8'h01, 8'h00, 8'h02);  // R9 through carry right
        issue(4'd14, 8'h5C, 8'h11, 8'hFF);  // R10 reserved
        issue(4'd15, 8'hA3, 8'h22, 8'h00);  // R10 reserved
        idle(3);

        // random, back-to-back and gapped
        for (int i = 0; i < 600; i++) begin
            issue(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom), 8'($urandom));
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(4);
        check("R2", "all results delivered", 8'(q.size()), 8'd0);
        check("R2", "valid count", 8'(seen - issued), 8'd0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule